// File: doc/BRIEF.md
# Descriptor Condition Evaluator

This unit sits beside a descriptor sequencer in a DMA channel and answers three yes/no questions about the descriptor currently being completed. It answers whether to raise an interrupt, whether to jump to the descriptor's dependent address instead of advancing to the next one, and whether to hold the channel in a wait state. Each question has its own select word holding a 4-bit mask and a 4-bit compare value. Each question also has its own 2-bit mode field in the descriptor command word. The mask and value are matched against the low device-status bits of the channel.

The sequencer raises an evaluate strobe for one cycle when a command completes. In that same cycle the interrupt request appears as a single-cycle pulse. The branch and wait decisions are registered on the strobe's clock edge. They are held until the next strobe, so the sequencer can sample them in any later cycle. When the branch decision is low, the sequencer advances to the next descriptor.

Top module: `desc_cond_eval`

## Requirements
- R1: While `rst_n` is low, `branch_take` and `wait_hold` are 0. `irq_pulse` is 0 whenever `eval` is low.
- R2: For a select word, the mask is bits 19:16 and the compare value is bits 3:0. The condition is true when `dev_status[3:0]` equals the value on every bit where the mask is 1.
- R3: The mode fields of `cmd_word` sit at bits 5:4 for the interrupt, 3:2 for the branch and 1:0 for the wait. The codes are 00 never, 01 act if the condition is true, 10 act if the condition is false, and 11 always.
- R4: `irq_pulse` equals the interrupt decision in any cycle where `eval` is high, and it is combinational in that cycle.
- R5: On a rising clock edge with `eval` high, `branch_take` takes the branch decision. Without `eval` it holds its value.
- R6: On a rising clock edge with `eval` high, `wait_hold` takes the wait decision. Without `eval` it holds its value.
- R7: Each decision uses only its own select word (`int_sel`, `br_sel`, `wait_sel`) and its own mode field.
- R8: When a mask is zero, the condition is true. Mode 10 then never acts and mode 01 always acts.
- R9: Bits 7:4 of `dev_status`, select-word bits outside 19:16 and 3:0, and `cmd_word` bits 15:6 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval | input | 1 | Evaluate strobe from the sequencer at command completion |
| cmd_word | input | 16 | Descriptor command word carrying the three mode fields |
| int_sel | input | 32 | Interrupt select word (mask 19:16, value 3:0) |
| br_sel | input | 32 | Branch select word (mask 19:16, value 3:0) |
| wait_sel | input | 32 | Wait select word (mask 19:16, value 3:0) |
| dev_status | input | 8 | Device-status byte of the channel status register |
| irq_pulse | output | 1 | Interrupt request, high only in an evaluate cycle |
| branch_take | output | 1 | Registered branch decision |
| wait_hold | output | 1 | Registered wait decision |

## Verification
The bench targets a zero mask combined with the if-false mode. A design that compared unmasked bits would act there when it should not. It drives differing status bits 7:4 and noisy unused select and command bits, which catches a comparison that is too wide or a field read from the wrong position. It holds `eval` low while changing every input, which exposes registered decisions that drift between strobes or an interrupt that fires without a strobe. It also gives the three select words different contents, so a decision wired to the wrong select word disagrees with the model.

// File: rtl/desc_cond_eval.sv
module desc_cond_eval #(
  parameter int CMD_W    = 16,
  parameter int SEL_W    = 32,
  parameter int STAT_W   = 8,
  parameter int CMP_W    = 4,
  parameter int MASK_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic [SEL_W-1:0]  int_sel,
  input  logic [SEL_W-1:0]  br_sel,
  input  logic [SEL_W-1:0]  wait_sel,
  input  logic [STAT_W-1:0] dev_status,
  output logic              irq_pulse,
  output logic              branch_take,
  output logic              wait_hold
);
  localparam int WAIT_LSB = 0;
  localparam int BR_LSB   = 2;
  localparam int INT_LSB  = 4;

  function automatic logic cond_hit(input logic [SEL_W-1:0] sel,
                                    input logic [CMP_W-1:0] stat);
    logic [CMP_W-1:0] m;
    m = sel[MASK_LSB +: CMP_W];
    return ((stat ^ sel[CMP_W-1:0]) & m) == '0;
  endfunction

  function automatic logic acts(input logic [1:0] mode, input logic hit);
    case (mode)
      2'b00:   return 1'b0;
      2'b01:   return hit;
      2'b10:   return !hit;
      default: return 1'b1;
    endcase
  endfunction

  logic [CMP_W-1:0] stat_lo;
  logic int_do, br_do, wait_do;

  assign stat_lo = dev_status[CMP_W-1:0];
  assign int_do  = acts(cmd_word[INT_LSB +: 2],  cond_hit(int_sel,  stat_lo));
  assign br_do   = acts(cmd_word[BR_LSB +: 2],   cond_hit(br_sel,   stat_lo));
  assign wait_do = acts(cmd_word[WAIT_LSB +: 2], cond_hit(wait_sel, stat_lo));

  assign irq_pulse = eval && int_do;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      branch_take <= 1'b0;
      wait_hold   <= 1'b0;
    end else if (eval) begin
      branch_take <= br_do;
      wait_hold   <= wait_do;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{cmd_word, int_sel, br_sel, wait_sel, dev_status};
endmodule

module desc_cond_eval_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        eval,
  input logic [15:0] cmd_word,
  input logic [31:0] int_sel,
  input logic        irq_pulse,
  input logic        branch_take,
  input logic        wait_hold
);
  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (!branch_take && !wait_hold)); // R1
  AST_IRQ_NEEDS_EVAL: assert property (@(posedge clk) disable iff (!rst_n) irq_pulse |-> eval); // R4
  AST_BRANCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !eval |=> $stable(branch_take)); // R5
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !eval |=> $stable(wait_hold)); // R6
  AST_IRQ_NEVER: assert property (@(posedge clk) disable iff (!rst_n) (eval && cmd_word[5:4] == 2'b00) |-> !irq_pulse); // R3
  AST_BRANCH_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n) (eval && cmd_word[3:2] == 2'b11) |=> branch_take); // R3
  AST_WAIT_NEVER: assert property (@(posedge clk) disable iff (!rst_n) (eval && cmd_word[1:0] == 2'b00) |=> !wait_hold); // R3
  AST_ZERO_MASK_IFFALSE: assert property (@(posedge clk) disable iff (!rst_n) (eval && int_sel[19:16] == 4'h0 && cmd_word[5:4] == 2'b10) |-> !irq_pulse); // R8
endmodule

bind desc_cond_eval desc_cond_eval_chk u_chk (
  .clk(clk), .rst_n(rst_n), .eval(eval), .cmd_word(cmd_word), .int_sel(int_sel),
  .irq_pulse(irq_pulse), .branch_take(branch_take), .wait_hold(wait_hold)
);

// File: tb/tb_desc_cond_eval.sv
module tb_desc_cond_eval;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eval = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [31:0] int_sel = '0, br_sel = '0, wait_sel = '0;
  logic [7:0]  dev_status = '0;
  logic        irq_pulse, branch_take, wait_hold;

  int checks = 0;
  int errors = 0;
  logic exp_br = 1'b0, exp_wt = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_cond_eval dut (
    .clk(clk), .rst_n(rst_n), .eval(eval), .cmd_word(cmd_word),
    .int_sel(int_sel), .br_sel(br_sel), .wait_sel(wait_sel),
    .dev_status(dev_status), .irq_pulse(irq_pulse),
    .branch_take(branch_take), .wait_hold(wait_hold)
  );

  function automatic logic model_cond(input logic [31:0] sel, input logic [7:0] st);
    logic ok = 1'b1;
    for (int i = 0; i < 4; i++)
      if (sel[16+i] && (sel[i] != st[i])) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic model_act(input logic [1:0] mode, input logic c);
    if (mode == 2'b11) return 1'b1;
    if (mode == 2'b01) return c;
    if (mode == 2'b10) return !c;
    return 1'b0;
  endfunction

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", what, act, exp);
    end
  endtask

  task automatic step(input logic ev, input logic [15:0] cw, input logic [31:0] is,
                      input logic [31:0] bs, input logic [31:0] ws, input logic [7:0] st,
                      input string tag);
    logic ei, eb, ew;
    @(negedge clk);
    eval = ev; cmd_word = cw; int_sel = is; br_sel = bs; wait_sel = ws; dev_status = st;
    ei = ev && model_act(cw[5:4], model_cond(is, st));
    eb = model_act(cw[3:2], model_cond(bs, st));
    ew = model_act(cw[1:0], model_cond(ws, st));
    #1;
    check(irq_pulse, ei, {tag, " R4 irq"});
    @(posedge clk); #1;
    if (ev) begin exp_br = eb; exp_wt = ew; end
    check(branch_take, exp_br, {tag, " R5 branch"});
    check(wait_hold, exp_wt, {tag, " R6 wait"});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #(CLK_PERIOD * 3);
    check(branch_take, 1'b0, "R1 reset branch");
    check(wait_hold, 1'b0, "R1 reset wait");
    check(irq_pulse, 1'b0, "R1 reset irq");
    @(negedge clk); rst_n = 1'b1;

    // R8 zero mask: if-false never acts, if-true always acts
    step(1'b1, 16'h0028, 32'h0000_000F, 32'h0000_0005, 32'h0000_0000, 8'h0A, "R8 zeromask");
    step(1'b1, 16'h0015, 32'h0000_0003, 32'h0000_000C, 32'h0000_0001, 8'h00, "R8 zeromask true");
    // R2 full mask exact match vs mismatch
    step(1'b1, 16'h0015, 32'h000F_0005, 32'h000F_0005, 32'h000F_0004, 8'h05, "R2 fullmask");
    step(1'b1, 16'h002A, 32'h0008_0008, 32'h0001_0000, 32'h0002_0002, 8'h0B, "R2 partial");
    // R3 never and always codes
    step(1'b1, 16'h003F, 32'h000F_0000, 32'h000F_0000, 32'h000F_0000, 8'h0F, "R3 always");
    step(1'b1, 16'h0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 8'h00, "R3 never");
    // R9 ignored bits: noisy upper status, select and command bits
    step(1'b1, 16'hFFD5, 32'hFFF5_FFF5, 32'hFFF5_FFF5, 32'hFFF5_FFF5, 8'hF5, "R9 noise");
    step(1'b1, 16'hFFC0 | 16'h0015, 32'h0000_0000 | 32'h000F_0005, 32'h000F_0005, 32'h000F_0005, 8'h35, "R9 status high");
    // R7 independent selects
    step(1'b1, 16'h0015, 32'h000F_0003, 32'h000F_0004, 32'h000F_0003, 8'h03, "R7 indep");
    // R5/R6 hold without strobe, R1 irq low without eval
    step(1'b0, 16'h003F, 32'h0, 32'h0, 32'h0, 8'h00, "R5 hold");
    step(1'b0, 16'h0000, 32'h000F_0001, 32'h000F_0002, 32'h000F_0003, 8'h0F, "R6 hold");

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a, b, c;
      a = $urandom; b = $urandom; c = $urandom;
      if ($urandom_range(0, 3) == 0) a[19:16] = 4'h0;
      step(($urandom_range(0, 3) != 0), 16'($urandom), a, b, c, 8'($urandom), "R2 R3 R7 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule